// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-visible register file of an interrupt router. It decodes a small address space behind a simple one-access-per-cycle bus. A write at offset 0x00 loads an 8-bit select value. An access at offset 0x10 then reaches the register that select names. The registers are an identification register, a read-only version register, an arbitration register that mirrors the identification value, and a table of one 64-bit redirection entry per interrupt pin. Each entry is reached as two 32-bit halves. A third offset, 0x40, accepts an end-of-interrupt vector, but only in the newer revision of the block.

The table is exported whole so that the delivery logic beside this block can read it. That logic owns two status bits in every entry: remote-IRR (bit 14) and delivery status (bit 12). It sets and clears remote-IRR through pulse inputs and drives delivery status as a level. Software writes cannot change either bit. There is one exception: a write that leaves an entry edge-triggered (bit 15 clear) scrubs its remote-IRR. Every table write tells the delivery logic to rescan and to restart the pin's repeated-EOI count.

Top module: `irq_route_window`

## Requirements
- R1: Only address bits 7:0 are decoded, so any address whose low byte is 0x10 reaches the data window.
- R2: A write at offset 0x00 stores wdata[7:0] as the select value, and a read at offset 0x00 returns it zero-extended, whatever the access size.
- R3: Window accesses act only when the size is 4 bytes. A window read of another size returns 0, and a window write of another size changes nothing.
- R4: Selects 0x00 and 0x02 both read the stored 4-bit ID in bits 27:24, with all other bits 0. A 4-byte window write with select 0x00 loads wdata[27:24] into the ID.
- R5: Select 0x01 reads the VERSION parameter in bits 7:0 and NUM_PINS-1 in bits 23:16. Window writes with select 0x01 or 0x02 are ignored.
- R6: Select 0x10+2n reaches bits 31:0 of entry n and select 0x11+2n reaches bits 63:32. When n is NUM_PINS or more, the access reads 0 and a write is ignored. Selects 0x03 to 0x0F also read 0 and ignore writes.
- R7: A table write updates only the writable bits (0-11, 13, 15, 16 and 63:48). Bits 12 and 14 keep their current values, and all other bits read 0. Bit 14 of entry n is set by rirr_set[n] and cleared by rirr_clr[n], with clear winning. Bit 12 follows dstat_in[n] one cycle late.
- R8: If bit 15 of an entry is 0 after a table write, its bit 14 is 0 in the next cycle, even when rirr_set is high in the same cycle.
- R9: An accepted table write to entry n raises cnt_clr_o[n] and service_req_o for exactly the next cycle. No other access raises them.
- R10: When VERSION is 0x20, a 4-byte write at offset 0x40 pulses eoi_valid_o for one cycle, with eoi_vector_o equal to wdata[7:0]. Any other size, or VERSION 0x11, gives no pulse.
- R11: After reset, the select and ID are 0, bus_rdata is 0, all pulse outputs are low, and every entry is 0x0000_0000_0001_0000, which means masked.
- R12: Read data is registered. It appears in the cycle after a read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rirr_set | input | NUM_PINS | Per-pin pulse that sets remote-IRR |
| rirr_clr | input | NUM_PINS | Per-pin pulse that clears remote-IRR |
| dstat_in | input | NUM_PINS | Per-pin delivery-status level |
| rte_o | output | 64*NUM_PINS | All entries; entry n at bits 64n+63:64n |
| cnt_clr_o | output | NUM_PINS | Restart the repeated-EOI count of a pin |
| service_req_o | output | 1 | Request a delivery rescan |
| eoi_valid_o | output | 1 | End-of-interrupt pulse |
| eoi_vector_o | output | 8 | Vector carried with the EOI pulse |

## Verification
The assertions assume one access at most per cycle. They also assume that the bus and sideband inputs are defined, and held low, from reset onward. The bench meets both conditions by driving every input on the falling edge from a single procedure, and by holding them at zero while reset is applied. The remote-IRR hold check is only claimed when neither rirr_set nor rirr_clr is active for that pin. The directed part of the stimulus keeps those inputs quiet around the writes it checks for that property. A second instance built with VERSION 0x11 sees the same bus traffic, to confirm that it never produces an EOI.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam logic [7:0]  OFF_SELECT = 8'h00;
    localparam logic [7:0]  OFF_WINDOW = 8'h10;
    localparam logic [7:0]  OFF_EOI    = 8'h40;
    localparam logic [7:0]  SEL_IDENT  = 8'h00;
    localparam logic [7:0]  SEL_REV    = 8'h01;
    localparam logic [7:0]  SEL_ARBIT  = 8'h02;
    localparam logic [7:0]  SEL_TABLE  = 8'h10;
    localparam logic [2:0]  FULL_SIZE  = 3'd4;
    localparam int          BIT_DSTAT  = 12;
    localparam int          BIT_RIRR   = 14;
    localparam int          BIT_TRIG   = 15;
    localparam logic [63:0] RW_BITS    = 64'hFFFF_0000_0001_AFFF;
    localparam logic [63:0] RO_BITS    = 64'h0000_0000_0000_5000;
    localparam logic [63:0] ENTRY_INIT = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_IDENT,
        TGT_REV,
        TGT_ARBIT,
        TGT_TABLE
    } win_tgt_e;
endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic [7:0] sel_i,
    output win_tgt_e   tgt_o,
    output logic [6:0] idx_o,
    output logic       hi_o
);
    logic [7:0] rel;

    always_comb begin
        rel   = sel_i - SEL_TABLE;
        idx_o = rel[7:1];
        hi_o  = sel_i[0];
        if (sel_i == SEL_IDENT)                         tgt_o = TGT_IDENT;
        else if (sel_i == SEL_REV)                      tgt_o = TGT_REV;
        else if (sel_i == SEL_ARBIT)                    tgt_o = TGT_ARBIT;
        else if (sel_i >= SEL_TABLE && int'(idx_o) < NUM_PINS) tgt_o = TGT_TABLE;
        else                                            tgt_o = TGT_NONE;
    end
endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        dstat_in,
    output logic [63:0] entry_o
);
    typedef struct packed {
        logic [63:0] ent;
    } ent_state_t;

    ent_state_t  st_d, st_q;
    logic [63:0] upd_d, merged_d;

    always_comb begin
        upd_d            = st_q.ent;
        upd_d[BIT_RIRR]  = (st_q.ent[BIT_RIRR] | rirr_set) & ~rirr_clr;
        upd_d[BIT_DSTAT] = dstat_in;
        merged_d = wr_hi ? {wdata, st_q.ent[31:0]} : {st_q.ent[63:32], wdata};
        st_d.ent = upd_d;
        if (wr_lo || wr_hi) begin
            st_d.ent = (merged_d & RW_BITS) | (upd_d & RO_BITS);
            if (!st_d.ent[BIT_TRIG]) st_d.ent[BIT_RIRR] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ent <= ENTRY_INIT;
        else        st_q     <= st_d;
    end

    assign entry_o = st_q.ent;

    // R8
    edge_scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_lo && !wdata[BIT_TRIG]) || (wr_hi && !entry_o[BIT_TRIG])) |=> !entry_o[BIT_RIRR]);

    // R7
    ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !rirr_set && !rirr_clr && entry_o[BIT_TRIG])
        |=> entry_o[BIT_RIRR] == $past(entry_o[BIT_RIRR]));
endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
    import irw_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter int          ADDR_W   = 12,
    parameter logic [7:0]  VERSION  = 8'h20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [2:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   rirr_set,
    input  logic [NUM_PINS-1:0]   rirr_clr,
    input  logic [NUM_PINS-1:0]   dstat_in,
    output logic [64*NUM_PINS-1:0] rte_o,
    output logic [NUM_PINS-1:0]   cnt_clr_o,
    output logic                  service_req_o,
    output logic                  eoi_valid_o,
    output logic [7:0]            eoi_vector_o
);
    localparam logic [7:0] MAX_ENTRY = 8'(NUM_PINS - 1);
    localparam bit         EOI_EN    = (VERSION == 8'h20);

    initial begin : version_param_chk
        assert (VERSION == 8'h11 || VERSION == 8'h20)
            else $error("VERSION must be 0x11 or 0x20");
    end

    typedef struct packed {
        logic [7:0]          sel;
        logic [3:0]          ident;
        logic [31:0]         rdata;
        logic                eoi_v;
        logic [7:0]          eoi_vec;
        logic                svc;
        logic [NUM_PINS-1:0] cnt_clr;
    } top_state_t;

    top_state_t st_d, st_q;

    win_tgt_e   tgt;
    logic [6:0] idx;
    logic       hi;
    logic [7:0] off;
    logic       win_ok, wr_acc, rd_acc, tbl_wr;
    logic [31:0] win_val, rd_val;
    logic [63:0] ent [NUM_PINS];
    logic [NUM_PINS-1:0] wr_lo_v, wr_hi_v;
    logic        unused_addr;

    assign unused_addr = ^bus_addr[ADDR_W-1:8];

    irw_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .sel_i (st_q.sel),
        .tgt_o (tgt),
        .idx_o (idx),
        .hi_o  (hi)
    );

    assign off    = bus_addr[7:0];
    assign wr_acc = bus_valid && bus_write;
    assign rd_acc = bus_valid && !bus_write;
    assign win_ok = bus_valid && (off == OFF_WINDOW) && (bus_size == FULL_SIZE);
    assign tbl_wr = wr_acc && win_ok && (tgt == TGT_TABLE);

    always_comb begin
        win_val = '0;
        case (tgt)
            TGT_IDENT, TGT_ARBIT: win_val = {4'b0, st_q.ident, 24'b0};
            TGT_REV:              win_val = {8'b0, MAX_ENTRY, 8'b0, VERSION};
            TGT_TABLE: begin
                for (int i = 0; i < NUM_PINS; i++) begin
                    if (idx == 7'(i)) win_val = hi ? ent[i][63:32] : ent[i][31:0];
                end
            end
            default:              win_val = '0;
        endcase
        if (off == OFF_SELECT)  rd_val = {24'b0, st_q.sel};
        else if (win_ok)        rd_val = win_val;
        else                    rd_val = '0;
    end

    always_comb begin
        st_d         = st_q;
        st_d.eoi_v   = 1'b0;
        st_d.svc     = 1'b0;
        st_d.cnt_clr = '0;
        if (wr_acc && off == OFF_SELECT) st_d.sel = bus_wdata[7:0];
        if (wr_acc && win_ok && tgt == TGT_IDENT) st_d.ident = bus_wdata[27:24];
        if (tbl_wr) begin
            st_d.svc = 1'b1;
            for (int i = 0; i < NUM_PINS; i++) begin
                if (idx == 7'(i)) st_d.cnt_clr[i] = 1'b1;
            end
        end
        if (EOI_EN && wr_acc && off == OFF_EOI && bus_size == FULL_SIZE) begin
            st_d.eoi_v   = 1'b1;
            st_d.eoi_vec = bus_wdata[7:0];
        end
        if (rd_acc) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
        assign wr_lo_v[g] = tbl_wr && (idx == 7'(g)) && !hi;
        assign wr_hi_v[g] = tbl_wr && (idx == 7'(g)) && hi;
        irw_entry u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo_v[g]),
            .wr_hi    (wr_hi_v[g]),
            .wdata    (bus_wdata),
            .rirr_set (rirr_set[g]),
            .rirr_clr (rirr_clr[g]),
            .dstat_in (dstat_in[g]),
            .entry_o  (ent[g])
        );
        assign rte_o[64*g +: 64] = ent[g];
    end

    assign bus_rdata     = st_q.rdata;
    assign cnt_clr_o     = st_q.cnt_clr;
    assign service_req_o = st_q.svc;
    assign eoi_valid_o   = st_q.eoi_v;
    assign eoi_vector_o  = st_q.eoi_vec;

    // R10
    eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid_o |-> $past(bus_valid && bus_write && bus_addr[7:0] == OFF_EOI
                              && bus_size == FULL_SIZE));

    if (!EOI_EN) begin : g_no_eoi
        // R10
        eoi_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) !eoi_valid_o);
    end

    // R9
    service_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        service_req_o |-> $past(bus_valid && bus_write && bus_addr[7:0] == OFF_WINDOW
                                && bus_size == FULL_SIZE));

    // R9
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_clr_o) && ($countones(cnt_clr_o) == 32'(service_req_o)));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

    // R4
    ident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> $stable(st_q.ident));
endmodule

// File: tb/irq_route_window_bench.sv
module irq_route_window_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P = 24;
    localparam logic [63:0] RWM = 64'hFFFF_0000_0001_AFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [P-1:0] set_v = '0, clr_v = '0, dst_v = '0;
    logic [31:0] rdata, rdata11;
    logic [64*P-1:0] rte;
    logic [4*64-1:0] rte11;
    logic [P-1:0] cclr;
    logic [3:0] cclr11;
    logic svc, svc11, eoi, eoi11;
    logic [7:0] eoiv, eoiv11;

    int checks = 0, fails = 0;
    string cur_req = "R11";

    logic [63:0] m_ent [P];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [31:0] m_rd;
    bit          chk11 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_window #(.NUM_PINS(P), .ADDR_W(12), .VERSION(8'h20)) u_irq_route_window (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .rirr_set(set_v), .rirr_clr(clr_v), .dstat_in(dst_v),
        .rte_o(rte), .cnt_clr_o(cclr), .service_req_o(svc),
        .eoi_valid_o(eoi), .eoi_vector_o(eoiv));

    irq_route_window #(.NUM_PINS(4), .ADDR_W(12), .VERSION(8'h11)) u_v11 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rdata11), .rirr_set(set_v[3:0]), .rirr_clr(clr_v[3:0]),
        .dstat_in(dst_v[3:0]), .rte_o(rte11), .cnt_clr_o(cclr11),
        .service_req_o(svc11), .eoi_valid_o(eoi11), .eoi_vector_o(eoiv11));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] win_read(input logic [7:0] s);
        int ix;
        if (s == 8'h00 || s == 8'h02) return {4'b0, m_id, 24'b0};
        if (s == 8'h01) return 32'h20 | ((P - 1) << 16);
        if (s < 8'h10) return 0;
        ix = (int'(s) - 16) / 2;
        if (ix >= P) return 0;
        return s[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
    endfunction

    task automatic step(input bit v, input bit w, input logic [11:0] a,
                        input logic [2:0] sz, input logic [31:0] wd);
        logic [63:0] nxt [P];
        logic [7:0] o;
        logic [63:0] mg;
        logic [31:0] rdn;
        logic [7:0] nsel;
        logic [3:0] nid;
        logic [P-1:0] clre;
        bit win4, svce, eoie;
        int ix;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = wd;
        o = a[7:0];
        win4 = v && o == 8'h10 && sz == 3'd4;
        rdn = m_rd;
        if (v && !w) rdn = (o == 8'h00) ? {24'b0, m_sel} : (win4 ? win_read(m_sel) : 32'h0);
        for (int n = 0; n < P; n++) begin
            nxt[n] = m_ent[n];
            nxt[n][14] = (nxt[n][14] | set_v[n]) & ~clr_v[n];
            nxt[n][12] = dst_v[n];
        end
        svce = 0; clre = '0; nsel = m_sel; nid = m_id;
        if (v && w && o == 8'h00) nsel = wd[7:0];
        if (v && w && win4 && m_sel == 8'h00) nid = wd[27:24];
        if (v && w && win4 && m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < P) begin
            ix = (int'(m_sel) - 16) / 2;
            mg = m_ent[ix];
            if (m_sel[0]) mg[63:32] = wd; else mg[31:0] = wd;
            nxt[ix] = (mg & RWM) | (nxt[ix] & 64'h5000);
            if (!nxt[ix][15]) nxt[ix][14] = 1'b0;
            svce = 1; clre[ix] = 1'b1;
        end
        eoie = v && w && o == 8'h40 && sz == 3'd4;
        @(posedge clk);
        #1;
        chk({cur_req, " R12 read data"}, 64'(rdata), 64'(rdn));
        for (int n = 0; n < P; n++) chk("R7 table entry", rte[64*n +: 64], nxt[n]);
        chk("R9 count clear", 64'(cclr), 64'(clre));
        chk("R9 service request", 64'(svc), 64'(svce));
        chk("R10 eoi valid", 64'(eoi), 64'(eoie));
        if (eoie) chk("R10 eoi vector", 64'(eoiv), 64'(wd[7:0]));
        chk("R10 version 0x11 eoi", 64'(eoi11), 64'h0);
        if (chk11) chk("R5 version 0x11 read", 64'(rdata11), 64'h0003_0011);
        for (int n = 0; n < P; n++) m_ent[n] = nxt[n];
        m_sel = nsel; m_id = nid; m_rd = rdn;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1, 1, a, 3'd4, d);
    endtask
    task automatic rd(input logic [11:0] a);
        step(1, 0, a, 3'd4, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        for (int n = 0; n < P; n++) m_ent[n] = 64'h0000_0000_0001_0000;
        m_sel = 0; m_id = 0; m_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R11: reset state via idle cycle
        cur_req = "R11";
        step(0, 0, 12'h0, 3'd0, 32'h0);
        chk("R11 rdata after reset", 64'(rdata), 64'h0);
        // R2: select register
        cur_req = "R2";
        wr(12'h000, 32'hFFFF_FF5A);
        rd(12'h000);
        step(1, 0, 12'h000, 3'd1, 0);
        // R4: ident and arbitration
        cur_req = "R4";
        wr(12'h000, 32'h0);
        wr(12'h010, 32'hA5FF_FFFF);
        rd(12'h010);
        wr(12'h000, 32'h2);
        rd(12'h010);
        // R5: writes to arbitration and version ignored
        cur_req = "R5";
        wr(12'h010, 32'h0F00_0000);
        rd(12'h010);
        wr(12'h000, 32'h1);
        wr(12'h010, 32'hFFFF_FFFF);
        chk11 = 1; rd(12'h010); chk11 = 0;
        // R3: size gating
        cur_req = "R3";
        wr(12'h000, 32'h16);
        step(1, 1, 12'h010, 3'd2, 32'h0000_00AB);
        step(1, 0, 12'h010, 3'd1, 0);
        rd(12'h010);
        // R1: upper address bits ignored
        cur_req = "R1";
        wr(12'h310, 32'h0000_80C1);
        rd(12'hA10);
        // R6: high half, last entry, out of range
        cur_req = "R6";
        wr(12'h000, 32'h17);
        wr(12'h010, 32'hDEAD_BEEF);
        rd(12'h010);
        wr(12'h000, 32'h3F);
        wr(12'h010, 32'h1234_5678);
        rd(12'h010);
        wr(12'h000, 32'h40);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010);
        wr(12'h000, 32'h05);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010);
        // R7: read-only bits survive writes
        cur_req = "R7";
        dst_v = 24'h00_0008;
        set_v[3] = 1'b1;
        step(0, 0, 0, 0, 0);
        set_v[3] = 1'b0;
        wr(12'h000, 32'h16);
        wr(12'h010, 32'hFFFF_AFFF);
        wr(12'h000, 32'h17);
        wr(12'h010, 32'h0000_0000);
        rd(12'h010);
        wr(12'h000, 32'h16);
        rd(12'h010);
        // R8: turning the entry edge scrubs remote-IRR, even against a set
        cur_req = "R8";
        set_v[3] = 1'b1;
        wr(12'h010, 32'h0000_0041);
        set_v[3] = 1'b0;
        rd(12'h010);
        clr_v[3] = 1'b1; set_v[3] = 1'b1;
        step(0, 0, 0, 0, 0);
        clr_v[3] = 1'b0; set_v[3] = 1'b0;
        // R10: explicit EOI
        cur_req = "R10";
        wr(12'h040, 32'h0000_0133);
        step(1, 1, 12'h040, 3'd2, 32'h77);
        wr(12'hF40, 32'h0000_00EE);
        // R9 and general mix: pseudo-random traffic
        cur_req = "R9";
        for (int k = 0; k < 600; k++) begin
            int op;
            logic [31:0] r;
            op = $urandom_range(0, 9);
            r = $urandom;
            set_v = 24'($urandom) & 24'($urandom);
            clr_v = 24'($urandom) & 24'($urandom) & 24'($urandom);
            dst_v = 24'($urandom);
            case (op)
                0, 1: wr(12'h000, 32'($urandom_range(0, 70)));
                2, 3, 4: wr(12'h010, r);
                5, 6: rd(12'h010);
                7: step(1, $urandom_range(0, 1) == 1, 12'h010, 3'($urandom_range(1, 3)), r);
                8: wr(12'h040, r);
                default: rd(12'h000);
            endcase
        end
        set_v = '0; clr_v = '0;
        step(0, 0, 0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule